// File: doc/BRIEF.md
# Coarse-Fine Successive-Approximation Sequencer

This block is the digital controller of a successive-approximation converter. Its code register feeds an external DAC, and it reads back one comparator bit. A one-cycle start request puts the sample-and-hold into hold. The block then decides the result bits one at a time, from the most significant bit down. When the conversion ends it releases the hold and reports the final code with a one-cycle done pulse.

A mode input selects between two ways of running a conversion. In full mode every bit is searched. In hybrid mode the upper `COARSE_W` bits come from a coarse flash code in the same cycle that the conversion is accepted, and only the lower bits are searched. This shortens a conversion from `2*RES_W` to `2*(RES_W-COARSE_W)` clocks. Each bit takes two clocks. The first clock places the trial bit on the DAC. The comparator is read on the next clock, which gives the DAC and comparator one full cycle to settle.

Top module: `hybrid_sar_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the cycle after it is released, `dac_code_o`, `hold_o`, `busy_o`, `done_o` and `result_o` are all zero.
- R2: A start request (`start_i`=1) seen at a clock edge while idle makes `hold_o` and `busy_o` high after that edge. Both stay high until the edge that completes the conversion.
- R3: In full mode (`hybrid_i`=0 when the request is accepted), the DAC code right after the accepting edge has only bit `RES_W-1` set.
- R4: `cmp_i`=1 means the held input is greater than or equal to the current DAC level. `cmp_i` is sampled one clock after the edge that placed a trial bit. At that edge the trial bit is kept if `cmp_i`=1 and cleared if `cmp_i`=0. On the following edge the next lower bit is set to 1. Trial edges and decision edges alternate.
- R5: Bits are tried strictly from the highest searched bit down to bit 0. At most one bit of the DAC code changes per clock during a conversion.
- R6: In hybrid mode (`hybrid_i`=1 when accepted), the accepting edge loads `coarse_i` into DAC code bits `[RES_W-1:RES_W-COARSE_W]` and sets bit `RES_W-COARSE_W-1` as the first trial. The upper bits then do not change for the rest of the conversion.
- R7: `done_o` goes high exactly `2*RES_W` clocks after the accepting edge in full mode, and `2*(RES_W-COARSE_W)` clocks after it in hybrid mode. The accepting edge counts as the first clock, so the figures are 24 and 8 for the default 12/8.
- R8: `done_o` is high for exactly one clock. In that clock `hold_o` and `busy_o` are already low, and `result_o` holds the final code. `result_o` keeps that value until the next completion.
- R9: A start request that arrives while busy is ignored. The running conversion keeps its mode, its timing and its result.
- R10: With an ideal DAC and comparator, every input code 0..2^RES_W-1 converts to itself in full mode. It also converts to itself in hybrid mode when the coarse code equals its upper `COARSE_W` bits.
- R11: For a 5 V unipolar full scale and a 3 V held input, the 12-bit result is 0x999 (1001_1001_1001). The same input with `RES_W`=2 gives binary 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, ignored while busy |
| hybrid_i | input | 1 | 1: load upper bits from coarse code, 0: search all bits |
| coarse_i | input | COARSE_W | Coarse flash code for the upper bits |
| cmp_i | input | 1 | Comparator: 1 when held input >= DAC level |
| dac_code_o | output | RES_W | Code driving the external DAC |
| hold_o | output | 1 | Sample-and-hold hold command |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | RES_W | Final code, valid from done_o onward |

## Verification
An ideal DAC and comparator model drives `cmp_i`. The bench first sweeps every 12-bit code in full mode, and then again in hybrid mode with a matching coarse code. A wrong bit order, a lost decision or an off-by-one bit in either path shows up as a code that does not convert to itself. Two step-by-step traces, one per mode, compare the DAC code at every clock against the expected trial and decision sequence, which separates timing faults from decision faults. A hybrid run with a coarse code that does not match the input shows that the upper bits really come from `coarse_i` and are never searched. The 3 V case at 12 and 2 bits checks a non-power-of-two level, and a start request injected in the middle of a conversion checks that it is ignored.

// File: rtl/hsar_pkg.sv
package hsar_pkg;
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_DECIDE  = 2'd1,
      PH_ADVANCE = 2'd2
   } phase_e;
endpackage

// File: rtl/hsar_sequencer.sv
// Phase control and one-hot pointer to the bit under test.
module hsar_sequencer
   import hsar_pkg::*;
#(
   parameter int RES_W    = 12,
   parameter int COARSE_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic             hybrid_i,
   output logic             load_o,
   output logic [RES_W-1:0] first_o,
   output logic             decide_o,
   output logic             advance_o,
   output logic             last_o,
   output logic [RES_W-1:0] probe_o,
   output logic             busy_o
);
   localparam logic [RES_W-1:0] FULL_FIRST = {1'b1, {(RES_W-1){1'b0}}};
   localparam logic [RES_W-1:0] HYB_FIRST  = FULL_FIRST >> COARSE_W;

   phase_e           phase;
   logic [RES_W-1:0] probe;

   assign load_o    = start_i && (phase == PH_IDLE);
   assign first_o   = hybrid_i ? HYB_FIRST : FULL_FIRST;
   assign decide_o  = (phase == PH_DECIDE);
   assign advance_o = (phase == PH_ADVANCE);
   assign last_o    = decide_o && probe[0];
   assign probe_o   = probe;
   assign busy_o    = (phase != PH_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         probe <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (start_i) begin
                  phase <= PH_DECIDE;
                  probe <= first_o;
               end
            end
            PH_DECIDE:  phase <= probe[0] ? PH_IDLE : PH_ADVANCE;
            PH_ADVANCE: begin
               probe <= probe >> 1;
               phase <= PH_DECIDE;
            end
            default:    phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hsar_code_reg.sv
// Per-bit code register with coarse preload and the result capture.
module hsar_code_reg #(
   parameter int RES_W    = 12,
   parameter int COARSE_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load_i,
   input  logic                hybrid_i,
   input  logic [COARSE_W-1:0] coarse_i,
   input  logic [RES_W-1:0]    first_i,
   input  logic                decide_i,
   input  logic                advance_i,
   input  logic                last_i,
   input  logic [RES_W-1:0]    probe_i,
   input  logic                cmp_i,
   output logic [RES_W-1:0]    code_o,
   output logic [RES_W-1:0]    result_o,
   output logic                done_o
);
   localparam int LOW_W = RES_W - COARSE_W;

   logic [RES_W-1:0] code_q;
   logic [RES_W-1:0] code_nxt;
   logic [RES_W-1:0] load_val;
   logic [RES_W-1:0] probe_nxt;

   assign probe_nxt = probe_i >> 1;

   for (genvar gi = 0; gi < RES_W; gi++) begin : g_bit
      if (gi >= LOW_W) begin : g_upper
         assign load_val[gi] = hybrid_i ? coarse_i[gi-LOW_W] : first_i[gi];
      end else begin : g_lower
         assign load_val[gi] = first_i[gi];
      end
      assign code_nxt[gi] =
         load_i                                ? load_val[gi] :
         (decide_i && probe_i[gi] && !cmp_i)   ? 1'b0 :
         (advance_i && probe_nxt[gi])          ? 1'b1 :
                                                 code_q[gi];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q   <= '0;
         result_o <= '0;
         done_o   <= 1'b0;
      end else begin
         code_q <= code_nxt;
         done_o <= last_i;
         if (last_i) result_o <= code_nxt;
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/hybrid_sar_seq.sv
module hybrid_sar_seq #(
   parameter int RES_W    = 12,
   parameter int COARSE_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start_i,
   input  logic                hybrid_i,
   input  logic [COARSE_W-1:0] coarse_i,
   input  logic                cmp_i,
   output logic [RES_W-1:0]    dac_code_o,
   output logic                hold_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [RES_W-1:0]    result_o
);
   if (RES_W < 2) begin : g_bad_res
      $error("hybrid_sar_seq: RES_W must be at least 2");
   end
   if (COARSE_W < 1 || COARSE_W >= RES_W) begin : g_bad_coarse
      $error("hybrid_sar_seq: COARSE_W must lie in 1..RES_W-1");
   end

   logic             load_s, decide_s, advance_s, last_s, busy_s;
   logic [RES_W-1:0] first_s, probe_s;

   hsar_sequencer #(.RES_W(RES_W), .COARSE_W(COARSE_W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start_i   (start_i),
      .hybrid_i  (hybrid_i),
      .load_o    (load_s),
      .first_o   (first_s),
      .decide_o  (decide_s),
      .advance_o (advance_s),
      .last_o    (last_s),
      .probe_o   (probe_s),
      .busy_o    (busy_s)
   );

   hsar_code_reg #(.RES_W(RES_W), .COARSE_W(COARSE_W)) u_code (
      .clk       (clk),
      .rst       (rst),
      .load_i    (load_s),
      .hybrid_i  (hybrid_i),
      .coarse_i  (coarse_i),
      .first_i   (first_s),
      .decide_i  (decide_s),
      .advance_i (advance_s),
      .last_i    (last_s),
      .probe_i   (probe_s),
      .cmp_i     (cmp_i),
      .code_o    (dac_code_o),
      .result_o  (result_o),
      .done_o    (done_o)
   );

   assign busy_o = busy_s;
   assign hold_o = busy_s;
endmodule

// File: rtl/hybrid_sar_seq_checker.sv
module hybrid_sar_seq_checker #(
   parameter int RES_W    = 12,
   parameter int COARSE_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                start_i,
   input logic                hybrid_i,
   input logic [COARSE_W-1:0] coarse_i,
   input logic [RES_W-1:0]    dac_code_o,
   input logic                hold_o,
   input logic                busy_o,
   input logic                done_o
);
   localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

   p_accept_holds_r2: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o) |=> (hold_o && busy_o));

   p_full_first_trial_r3: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o && !hybrid_i) |=> (dac_code_o == TOP_BIT));

   p_one_bit_step_r5: assert property (@(posedge clk) disable iff (rst)
      (busy_o && $past(busy_o)) |-> ($countones(dac_code_o ^ $past(dac_code_o)) <= 1));

   p_coarse_load_r6: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o && hybrid_i) |=>
         (dac_code_o[RES_W-1 -: COARSE_W] == $past(coarse_i)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   p_done_released_r8: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!hold_o && !busy_o));

   p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
      (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind hybrid_sar_seq hybrid_sar_seq_checker #(.RES_W(RES_W), .COARSE_W(COARSE_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start_i    (start_i),
   .hybrid_i   (hybrid_i),
   .coarse_i   (coarse_i),
   .dac_code_o (dac_code_o),
   .hold_o     (hold_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/hybrid_sar_seq_bench.sv
module hybrid_sar_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 12;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          hybrid = 1'b0;
   logic [CW-1:0] coarse = '0;
   logic          cmp;
   logic [W-1:0]  dac, result;
   logic          hold, busy, done;
   longint        vin = 0;   // cmp = (dac*5 <= vin)

   logic          start2 = 1'b0;
   logic          cmp2;
   logic [1:0]    dac2, result2;
   logic          hold2, busy2, done2;
   longint        vin2 = 0;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign cmp  = (longint'(dac)  * 5 <= vin);
   assign cmp2 = (longint'(dac2) * 5 <= vin2);

   hybrid_sar_seq #(.RES_W(W), .COARSE_W(CW)) u_hybrid_sar_seq (
      .clk(clk), .rst(rst), .start_i(start), .hybrid_i(hybrid), .coarse_i(coarse),
      .cmp_i(cmp), .dac_code_o(dac), .hold_o(hold), .busy_o(busy),
      .done_o(done), .result_o(result));

   hybrid_sar_seq #(.RES_W(2), .COARSE_W(1)) u_hybrid_sar_seq_w2 (
      .clk(clk), .rst(rst), .start_i(start2), .hybrid_i(1'b0), .coarse_i(1'b0),
      .cmp_i(cmp2), .dac_code_o(dac2), .hold_o(hold2), .busy_o(busy2),
      .done_o(done2), .result_o(result2));

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog expired: actual %0d expected <190000", cyc);
         summary();
      end
   end

   // One conversion; optionally injects a start request mid-conversion.
   task automatic run_conv(input logic hyb, input logic [CW-1:0] crs, input bit poke,
                           output int lat, output logic [W-1:0] res);
      @(negedge clk);
      start = 1'b1; hybrid = hyb; coarse = crs;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         if (poke && lat == 5) begin
            start = 1'b1; hybrid = ~hyb; coarse = ~crs;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      res = result;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(dac == 0 && result == 0, "R1", "code/result under reset", {dac, result}, 0);
      check(!hold && !busy && !done, "R1", "flags under reset", {hold, busy, done}, 0);
      rst = 1'b0;
      @(negedge clk);
      check(dac == 0 && !hold && !busy && !done, "R1", "state after release",
            {dac, hold, busy, done}, 0);
   endtask

   // Clock-by-clock trace of DAC code against the expected trial/decide order.
   task automatic t_trace(input logic hyb, input logic [W-1:0] x);
      logic [W-1:0] acc;
      int top;
      vin = 5 * longint'(x);
      top = hyb ? W - CW - 1 : W - 1;
      acc = hyb ? {x[W-1 -: CW], {(W-CW){1'b0}}} : '0;
      @(negedge clk);
      start = 1'b1; hybrid = hyb; coarse = x[W-1 -: CW];
      @(negedge clk);
      start = 1'b0;
      check(hold && busy, "R2", "hold/busy after accept", {hold, busy}, 3);
      for (int b = top; b >= 0; b--) begin
         if (b != top) @(negedge clk);
         check(dac == (acc | (W'(1) << b)), hyb ? "R6" : "R3",
               "trial code", dac, acc | (W'(1) << b));
         if (x >= (acc | (W'(1) << b))) acc = acc | (W'(1) << b);
         @(negedge clk);
         check(dac == acc, "R4", "code after decision", dac, acc);
         if (b != 0) check(hold && busy && !done, "R2", "hold kept mid-conversion",
                           {hold, busy, done}, 6);
      end
      check(done && !hold && !busy, "R8", "done with hold released",
            {done, hold, busy}, 4);
      check(result == x, "R5", "trace result", result, x);
      @(negedge clk);
      check(!done && result == x, "R8", "done single cycle, result kept",
            {done, result}, x);
   endtask

   task automatic t_latency();
      int lat; logic [W-1:0] res;
      vin = 5 * 1234;
      run_conv(1'b0, 8'h00, 1'b0, lat, res);
      check(lat == 2 * W, "R7", "full-mode latency", lat, 2 * W);
      run_conv(1'b1, 8'(12'd1234 >> 4), 1'b0, lat, res);
      check(lat == 2 * (W - CW), "R7", "hybrid-mode latency", lat, 2 * (W - CW));
      check(res == 1234, "R6", "hybrid result", res, 1234);
   endtask

   task automatic t_coarse_mismatch();
      int lat; logic [W-1:0] res;
      vin = 5 * 12'h3FF;
      run_conv(1'b1, 8'h20, 1'b0, lat, res);
      check(res == 12'h20F, "R6", "upper bits from coarse code", res, 12'h20F);
      vin = 5 * 12'hFFF;
      run_conv(1'b1, 8'h00, 1'b0, lat, res);
      check(res == 12'h00F, "R6", "coarse zero, fine all ones", res, 12'h00F);
   endtask

   task automatic t_start_ignored();
      int lat; logic [W-1:0] res;
      vin = 5 * 12'h123;
      run_conv(1'b0, 8'h00, 1'b1, lat, res);
      check(res == 12'h123, "R9", "result with start while busy", res, 12'h123);
      check(lat == 2 * W, "R9", "latency with start while busy", lat, 2 * W);
      @(negedge clk);
      check(!busy && !hold, "R9", "no restart after completion", {busy, hold}, 0);
   endtask

   task automatic t_three_volt();
      int lat; logic [W-1:0] res;
      vin = 3 * 4096;
      run_conv(1'b0, 8'h00, 1'b0, lat, res);
      check(res == 12'h999, "R11", "3 V at 12 bits", res, 12'h999);
      vin2 = 3 * 4;
      @(negedge clk);
      start2 = 1'b1;
      @(negedge clk);
      start2 = 1'b0;
      lat = 1;
      while (!done2 && lat < 20) begin @(negedge clk); lat++; end
      check(result2 == 2'b10, "R11", "3 V at 2 bits", result2, 2'b10);
      check(lat == 4, "R7", "2-bit latency", lat, 4);
   endtask

   task automatic t_sweep(input logic hyb);
      int lat; logic [W-1:0] res; logic [W-1:0] xv; int bad = 0;
      for (int x = 0; x < (1 << W); x++) begin
         xv = W'(x);
         vin = 5 * longint'(x);
         run_conv(hyb, xv[W-1 -: CW], 1'b0, lat, res);
         if (res != xv) begin
            bad++;
            check(1'b0, "R10", hyb ? "hybrid sweep" : "full sweep", res, xv);
         end
      end
      check(bad == 0, "R10", hyb ? "hybrid sweep mismatches" : "full sweep mismatches",
            bad, 0);
   endtask

   initial begin
      t_reset();
      t_trace(1'b0, 12'hA5C);
      t_trace(1'b0, 12'h000);
      t_trace(1'b1, 12'h6B7);
      t_latency();
      t_coarse_mismatch();
      t_start_ignored();
      t_three_volt();
      t_sweep(1'b0);
      t_sweep(1'b1);
      summary();
   end
endmodule